// File: doc/BRIEF.md
# Serial One-Time-Programmable Security Region Controller

This block is the slave-side command logic of a serial memory device for one job: writing a 64-byte user security region exactly once. It listens on a four-wire serial bus in clock mode 0. Data on the input line is taken on the rising serial clock and the output line changes on the falling serial clock. The serial pins are brought into the system clock domain through synchronisers, and their edges are detected there. The block recognises three opcodes: latch-enable 0x06, status read 0x05 and region program 0x9B. It captures a 24-bit address, stages data bytes in the shared 256-byte page buffer, and judges the framing at the moment chip select is released.

A program command that is well framed and arrives while the region is still unlocked starts a self-timed cycle of `PROG_CYCLES` system clocks. At the end of that cycle the low 64 bytes of the buffer are copied into the region. A program command that is badly framed, or one that arrives after the region has been locked, is aborted. Both outcomes clear the write-enable latch. A status read can be issued at any time and reports busy and the latch state.

The serial pins form a bit-level bus with no back-pressure: the host owns the clock, and the block never stalls it. The region and buffer read ports are plain combinational lookups, used by the neighbouring array logic.

Top module: `otp_secreg_ctrl`

## Requirements
- R1: After reset, a status read returns 0x00, `spi_so_oe` is low while idle, every region byte reads 0xFF, and every buffer byte reads 0xFF.
- R2: Opcode 0x06, released on a whole-byte boundary while not busy, sets the write-enable latch. A status read then returns 0x02.
- R3: After the eighth bit of opcode 0x05, the status byte is driven MSB first, starting at the next falling serial clock edge, and it repeats for as long as clocks continue. Bit 0 is busy and bit 1 is the latch; the other bits are 0. `spi_so_oe` is high only in this phase.
- R4: Opcode 0x9B received with the latch clear is ignored. The region, the buffer and the status all stay unchanged.
- R5: A program command is accepted when all of the following hold: 3 address bytes and at least one complete data byte are received, chip select is released after a multiple of 8 bits, and the region is unlocked. Data byte k is then written to region offset (A[5:0]+k) mod 64, where A[5:0] is the low 6 bits of the third address byte. Region bytes that were not supplied read 0xFF. The region changes only when the busy period of PROG_CYCLES clocks ends.
- R6: A program command with an incomplete address, or with no complete data byte, programs nothing, leaves the block not busy, and clears the latch.
- R7: A program command released after a bit count that is not a multiple of 8 programs nothing, leaves the block not busy, and clears the latch.
- R8: Once a program has been accepted, the region is locked. Any later program command aborts, clears the latch and leaves the region unchanged.
- R9: When a program is accepted, the latch is cleared before busy rises. A status read during the busy period returns 0x01.
- R10: While busy, opcodes 0x06 and 0x9B are ignored. Status reads still work.
- R11: An admitted program opcode refills the whole page buffer with 0xFF. Each complete data byte k is then staged at buffer index (A[5:0]+k) mod 64. This happens even if the command later aborts.
- R12: `spi_so_oe` stays low for the whole of a program command.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| spi_sck | input | 1 | Serial clock from the host |
| spi_cs_n | input | 1 | Chip select, active low |
| spi_si | input | 1 | Serial data into the block |
| spi_so | output | 1 | Serial data out of the block |
| spi_so_oe | output | 1 | Output enable for `spi_so`; low means high impedance |
| otp_rd_idx | input | 6 | Region byte index for the read port |
| otp_rd_data | output | 8 | Region byte at `otp_rd_idx` |
| buf_rd_idx | input | 8 | Page buffer index for the read port |
| buf_rd_data | output | 8 | Buffer byte at `buf_rd_idx` |

## Verification
A wrong framing decision shows up at the very first status read after chip select is released. An abort that should have happened reads 0x01 where 0x00 was due, and an accept that should have happened reads the reverse. A bad offset or a bad fill state in the staging path shows up on the buffer port as soon as the command ends. The region port exposes it only once the busy time has run out. A lock or latch error is seen through the status read of the next command, so every such fault reaches the pins within one transaction.

// File: rtl/otp_secreg_pkg.sv
package otp_secreg_pkg;
  localparam logic [7:0] OP_LATCH_ON = 8'h06;
  localparam logic [7:0] OP_STATUS   = 8'h05;
  localparam logic [7:0] OP_PROGRAM  = 8'h9B;

  typedef enum logic [2:0] {
    CMD_NONE,
    CMD_LATCH,
    CMD_STAT,
    CMD_PROG,
    CMD_IGN
  } cmd_e;
endpackage

// File: rtl/otp_spi_sync.sv
module otp_spi_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic sck_in,
  input  logic cs_n_in,
  input  logic si_in,
  output logic sck_rise,
  output logic sck_fall,
  output logic cs_fall,
  output logic cs_rise,
  output logic cs_act,
  output logic si_s
);
  localparam int TOP = STAGES - 1;

  logic [STAGES-1:0] sck_sr, cs_sr, si_sr;
  logic sck_d, cs_d;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sck_sr <= '0;
      cs_sr  <= '1;
      si_sr  <= '0;
      sck_d  <= 1'b0;
      cs_d   <= 1'b1;
    end else begin
      sck_sr[0] <= sck_in;
      cs_sr[0]  <= cs_n_in;
      si_sr[0]  <= si_in;
      for (int i = 1; i < STAGES; i++) begin
        sck_sr[i] <= sck_sr[i-1];
        cs_sr[i]  <= cs_sr[i-1];
        si_sr[i]  <= si_sr[i-1];
      end
      sck_d <= sck_sr[TOP];
      cs_d  <= cs_sr[TOP];
    end
  end

  assign cs_act   = ~cs_sr[TOP];
  assign sck_rise = sck_sr[TOP] & ~sck_d & cs_act;
  assign sck_fall = ~sck_sr[TOP] & sck_d & cs_act;
  assign cs_fall  = ~cs_sr[TOP] & cs_d;
  assign cs_rise  = cs_sr[TOP] & ~cs_d;
  assign si_s     = si_sr[TOP];
endmodule

// File: rtl/otp_cmd_shifter.sv
module otp_cmd_shifter (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       sel_start,
  input  logic       bit_strobe,
  input  logic       bit_in,
  output logic       byte_valid,
  output logic [7:0] byte_data,
  output logic [2:0] byte_pos,
  output logic [2:0] byte_cnt,
  output logic [2:0] bit_phase
);
  logic [6:0] sr;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sr         <= '0;
      bit_phase  <= '0;
      byte_cnt   <= '0;
      byte_pos   <= '0;
      byte_valid <= 1'b0;
      byte_data  <= '0;
    end else begin
      byte_valid <= 1'b0;
      if (sel_start) begin
        sr        <= '0;
        bit_phase <= '0;
        byte_cnt  <= '0;
      end else if (bit_strobe) begin
        sr        <= {sr[5:0], bit_in};
        bit_phase <= bit_phase + 3'd1;
        if (bit_phase == 3'd7) begin
          byte_valid <= 1'b1;
          byte_data  <= {sr, bit_in};
          byte_pos   <= byte_cnt;
          if (byte_cnt != 3'd7) byte_cnt <= byte_cnt + 3'd1;
        end
      end
    end
  end

  // R7: the bit phase that judges framing moves only on a serial edge or a new select
  a_r7_phase_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    (!bit_strobe && !sel_start) |=> $stable(bit_phase));
endmodule

// File: rtl/otp_prog_engine.sv
module otp_prog_engine #(
  parameter int REGION_BYTES = 64,
  parameter int PROG_CYCLES  = 1000
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      start,
  input  logic [REGION_BYTES*8-1:0] stage_img,
  output logic                      busy,
  output logic                      locked,
  output logic [REGION_BYTES*8-1:0] region_img
);
  localparam int TMR_W = $clog2(PROG_CYCLES + 1);

  logic [TMR_W-1:0] timer;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy       <= 1'b0;
      locked     <= 1'b0;
      timer      <= '0;
      region_img <= '1;
    end else if (busy) begin
      if (timer == TMR_W'(1)) begin
        busy       <= 1'b0;
        region_img <= stage_img;
      end
      timer <= timer - TMR_W'(1);
    end else if (start && !locked) begin
      busy   <= 1'b1;
      locked <= 1'b1;
      timer  <= TMR_W'(PROG_CYCLES);
    end
  end

  // R8: the one-time lock never clears
  a_r8_lock_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    locked |=> locked);
  // R5: a program cycle only runs against a locked region
  a_r5_busy_locked: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> locked);
  // R5: outside a program cycle the region cannot change
  a_r5_region_frozen: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |=> $stable(region_img));
endmodule

// File: rtl/otp_secreg_ctrl.sv
module otp_secreg_ctrl
  import otp_secreg_pkg::*;
#(
  parameter int REGION_BYTES = 64,
  parameter int BUF_BYTES    = 256,
  parameter int PROG_CYCLES  = 1000,
  parameter int SYNC_STAGES  = 2
) (
  input  logic                            clk,
  input  logic                            rst_n,
  input  logic                            spi_sck,
  input  logic                            spi_cs_n,
  input  logic                            spi_si,
  output logic                            spi_so,
  output logic                            spi_so_oe,
  input  logic [$clog2(REGION_BYTES)-1:0] otp_rd_idx,
  output logic [7:0]                      otp_rd_data,
  input  logic [$clog2(BUF_BYTES)-1:0]    buf_rd_idx,
  output logic [7:0]                      buf_rd_data
);
  localparam int OFF_W = $clog2(REGION_BYTES);
  localparam int BUF_W = $clog2(BUF_BYTES);
  localparam int IMG_W = REGION_BYTES * 8;

  logic sck_rise, sck_fall, cs_fall, cs_rise, cs_act, si_s;
  logic       byte_valid;
  logic [7:0] byte_data;
  logic [2:0] byte_pos, byte_cnt, bit_phase;

  cmd_e             cmd_q;
  logic             wel;
  logic             busy, locked;
  logic             prog_start;
  logic [OFF_W-1:0] data_idx;
  logic [7:0]       buf_q [BUF_BYTES];
  logic [IMG_W-1:0] stage_img, region_img;
  logic             prog_admit, data_wr, frame_ok;
  logic [7:0]       status_byte;
  logic [6:0]       out_sr;
  logic [2:0]       out_idx;

  otp_spi_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n), .sck_in(spi_sck), .cs_n_in(spi_cs_n), .si_in(spi_si),
    .sck_rise(sck_rise), .sck_fall(sck_fall), .cs_fall(cs_fall), .cs_rise(cs_rise),
    .cs_act(cs_act), .si_s(si_s)
  );

  otp_cmd_shifter u_shift (
    .clk(clk), .rst_n(rst_n), .sel_start(cs_fall), .bit_strobe(sck_rise), .bit_in(si_s),
    .byte_valid(byte_valid), .byte_data(byte_data), .byte_pos(byte_pos),
    .byte_cnt(byte_cnt), .bit_phase(bit_phase)
  );

  otp_prog_engine #(.REGION_BYTES(REGION_BYTES), .PROG_CYCLES(PROG_CYCLES)) u_engine (
    .clk(clk), .rst_n(rst_n), .start(prog_start), .stage_img(stage_img),
    .busy(busy), .locked(locked), .region_img(region_img)
  );

  assign prog_admit  = byte_valid && (byte_pos == 3'd0) && (byte_data == OP_PROGRAM)
                       && wel && !busy;
  assign data_wr     = byte_valid && (cmd_q == CMD_PROG) && (byte_pos >= 3'd4);
  assign frame_ok    = (bit_phase == 3'd0) && (byte_cnt >= 3'd5);
  assign status_byte = {6'b0, wel, busy};

  // command decode, address capture, latch and framing judgement
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cmd_q      <= CMD_NONE;
      wel        <= 1'b0;
      data_idx   <= '0;
      prog_start <= 1'b0;
    end else begin
      prog_start <= 1'b0;
      if (cs_fall) begin
        cmd_q <= CMD_NONE;
      end else if (byte_valid) begin
        if (byte_pos == 3'd0) begin
          if (byte_data == OP_LATCH_ON && !busy) cmd_q <= CMD_LATCH;
          else if (byte_data == OP_STATUS)       cmd_q <= CMD_STAT;
          else if (prog_admit)                   cmd_q <= CMD_PROG;
          else                                   cmd_q <= CMD_IGN;
        end else if (cmd_q == CMD_PROG) begin
          if (byte_pos == 3'd3)      data_idx <= byte_data[OFF_W-1:0];
          else if (byte_pos >= 3'd4) data_idx <= data_idx + OFF_W'(1);
        end
      end
      if (cs_rise) begin
        if (cmd_q == CMD_PROG) begin
          wel        <= 1'b0;
          prog_start <= frame_ok && !locked;
        end else if (cmd_q == CMD_LATCH && bit_phase == 3'd0) begin
          wel <= 1'b1;
        end
        cmd_q <= CMD_NONE;
      end
    end
  end

  // shared page buffer: refilled on an admitted program opcode, then staged
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < BUF_BYTES; i++) buf_q[i] <= 8'hFF;
    end else if (prog_admit) begin
      for (int i = 0; i < BUF_BYTES; i++) buf_q[i] <= 8'hFF;
    end else if (data_wr) begin
      buf_q[BUF_W'(data_idx)] <= byte_data;
    end
  end

  genvar g;
  generate
    for (g = 0; g < REGION_BYTES; g++) begin : g_stage
      assign stage_img[g*8 +: 8] = buf_q[g];
    end
  endgenerate

  assign buf_rd_data = buf_q[buf_rd_idx];
  assign otp_rd_data = region_img[otp_rd_idx*8 +: 8];

  // status output, changed on the falling serial edge
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      spi_so    <= 1'b0;
      spi_so_oe <= 1'b0;
      out_sr    <= '0;
      out_idx   <= '0;
    end else if (!cs_act) begin
      spi_so_oe <= 1'b0;
      out_idx   <= '0;
    end else if (sck_fall && cmd_q == CMD_STAT) begin
      spi_so_oe <= 1'b1;
      out_idx   <= out_idx + 3'd1;
      if (out_idx == 3'd0) begin
        spi_so <= status_byte[7];
        out_sr <= status_byte[6:0];
      end else begin
        spi_so <= out_sr[6];
        out_sr <= {out_sr[5:0], 1'b0};
      end
    end
  end

  // R3: the output driver lets go one cycle after deselection
  a_r3_so_released: assert property (@(posedge clk) disable iff (!rst_n)
    !cs_act |=> !spi_so_oe);
  // R12: no drive while a program command is being clocked in
  a_r12_quiet_in_prog: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_q == CMD_PROG) |-> !spi_so_oe);
  // R9: the latch is already low when the program cycle begins
  a_r9_wel_low_at_start: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> !wel);
  // R10: the latch cannot be set during a program cycle
  a_r10_latch_held: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !wel) |=> !wel);
endmodule

// File: tb/otp_secreg_ctrl_bench.sv
`timescale 1ns/1ps
module otp_secreg_ctrl_bench;
  localparam int HALF = 6;
  localparam int NV   = 7;
  // fields: [16] latch first, [15:14] address bytes, [13:10] data bytes,
  //         [9:7] stray bits, [6:1] start offset, [0] expect accept
  localparam logic [16:0] VEC [NV] = '{
    {1'b1, 2'd3, 4'd1, 3'd0, 6'd5,  1'b1},
    {1'b1, 2'd3, 4'd4, 3'd0, 6'd62, 1'b1},
    {1'b1, 2'd3, 4'd0, 3'd0, 6'd9,  1'b0},
    {1'b1, 2'd2, 4'd0, 3'd0, 6'd9,  1'b0},
    {1'b1, 2'd3, 4'd2, 3'd3, 6'd17, 1'b0},
    {1'b0, 2'd3, 4'd2, 3'd0, 6'd20, 1'b0},
    {1'b1, 2'd3, 4'd0, 3'd5, 6'd30, 1'b0}
  };

  logic clk = 1'b0, rst_n = 1'b0, sck = 1'b0, cs_n = 1'b1, si = 1'b0;
  logic so, so_oe;
  logic [5:0] rd_idx = '0;
  logic [7:0] rd_data;
  logic [7:0] bidx = '0;
  logic [7:0] bdata;
  int   n_chk = 0, n_fail = 0;
  bit   oe_seen;
  logic [7:0] exp_reg [64];

  always #2 clk = ~clk;

  otp_secreg_ctrl u_otp_secreg_ctrl (
    .clk(clk), .rst_n(rst_n), .spi_sck(sck), .spi_cs_n(cs_n), .spi_si(si),
    .spi_so(so), .spi_so_oe(so_oe), .otp_rd_idx(rd_idx), .otp_rd_data(rd_data),
    .buf_rd_idx(bidx), .buf_rd_data(bdata)
  );

  task automatic check(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic spi_bit(input logic b, output logic o);
    si = b;
    tick(HALF);
    o = so;
    if (so_oe) oe_seen = 1'b1;
    sck = 1'b1;
    tick(HALF);
    sck = 1'b0;
  endtask

  task automatic send_byte(input logic [7:0] v);
    logic d;
    for (int i = 7; i >= 0; i--) spi_bit(v[i], d);
  endtask

  task automatic cs_on;
    cs_n = 1'b0;
    tick(2 * HALF);
  endtask

  task automatic cs_off;
    tick(HALF);
    cs_n = 1'b1;
    tick(2 * HALF);
  endtask

  task automatic read_status(output logic [7:0] s);
    logic b;
    cs_on();
    send_byte(8'h05);
    for (int i = 7; i >= 0; i--) begin
      spi_bit(1'b0, b);
      s[i] = b;
    end
    cs_off();
  endtask

  task automatic latch_on;
    cs_on();
    send_byte(8'h06);
    cs_off();
  endtask

  function automatic logic [7:0] data_of(input int seed, input int k);
    return 8'(seed * 16 + k * 29 + 3);
  endfunction

  task automatic prog(input int naddr, input int ndata, input int extra,
                      input logic [5:0] off, input int seed);
    logic d;
    cs_on();
    send_byte(8'h9B);
    for (int a = 0; a < naddr; a++)
      send_byte(a == 2 ? {2'b10, off} : 8'h00);
    for (int k = 0; k < ndata; k++) send_byte(data_of(seed, k));
    for (int e = 0; e < extra; e++) spi_bit(1'b1, d);
    cs_off();
  endtask

  task automatic wait_idle;
    logic [7:0] s;
    for (int p = 0; p < 40; p++) begin
      read_status(s);
      if (!s[0]) break;
    end
  endtask

  task automatic do_reset;
    rst_n = 1'b0;
    cs_n = 1'b1;
    sck = 1'b0;
    tick(4);
    rst_n = 1'b1;
    tick(4);
  endtask

  task automatic check_region(input string req);
    int bad;
    int first_act;
    int first_exp;
    bad = 0;
    first_act = 0;
    first_exp = 0;
    for (int i = 0; i < 64; i++) begin
      rd_idx = 6'(i);
      tick(1);
      if (rd_data != exp_reg[i]) begin
        if (bad == 0) begin
          first_act = int'(rd_data);
          first_exp = int'(exp_reg[i]);
        end
        bad++;
      end
    end
    check(req, first_act, first_exp);
  endtask

  task automatic read_buf(input int idx, output logic [7:0] v);
    bidx = 8'(idx);
    tick(1);
    v = bdata;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog: run did not finish actual=hung expected=done");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    logic [7:0] s, s2, bv;
    logic [16:0] e;
    logic b;
    int naddr, ndata, extra, off;
    string tag;

    // vector table
    for (int v = 0; v < NV; v++) begin
      e = VEC[v];
      naddr = int'(e[15:14]);
      ndata = int'(e[13:10]);
      extra = int'(e[9:7]);
      off   = int'(e[6:1]);
      tag = e[0] ? "R5" : (!e[16] ? "R4" : ((extra != 0) ? "R7" : "R6"));
      do_reset();
      if (e[16]) latch_on();
      prog(naddr, ndata, extra, 6'(off), v);
      read_status(s);
      check({tag, " status after program command"}, int'(s), e[0] ? 8'h01 : 8'h00);
      wait_idle();
      for (int i = 0; i < 64; i++) exp_reg[i] = 8'hFF;
      if (e[0])
        for (int k = 0; k < ndata; k++) exp_reg[(off + k) % 64] = data_of(v, k);
      check_region({tag, " region contents"});
      if (e[16] && ndata > 0) begin
        for (int k = 0; k < ndata; k++) begin
          read_buf((off + k) % 64, bv);
          check("R11 staged byte in buffer", int'(bv), int'(data_of(v, k)));
        end
      end
      if (!e[16]) begin
        read_buf(off, bv);
        check("R4 buffer untouched when latch clear", int'(bv), 8'hFF);
      end
    end

    // reset state
    do_reset();
    check("R1 output disabled at idle", int'(so_oe), 0);
    read_status(s);
    check("R1 status after reset", int'(s), 8'h00);
    for (int i = 0; i < 64; i++) exp_reg[i] = 8'hFF;
    check_region("R1 region erased after reset");
    read_buf(255, bv);
    check("R1 buffer top byte after reset", int'(bv), 8'hFF);

    // latch and repeated status byte
    latch_on();
    oe_seen = 1'b0;
    cs_on();
    send_byte(8'h05);
    for (int i = 7; i >= 0; i--) begin spi_bit(1'b0, b); s[i] = b; end
    for (int i = 7; i >= 0; i--) begin spi_bit(1'b0, b); s2[i] = b; end
    cs_off();
    check("R2 latch set by 0x06", int'(s), 8'h02);
    check("R3 status repeats", int'(s2), 8'h02);
    check("R3 output enabled during status", int'(oe_seen), 1);
    check("R3 output released after status", int'(so_oe), 0);

    // accepted program, busy period
    oe_seen = 1'b0;
    prog(3, 3, 0, 6'd40, 9);
    check("R12 no output drive during program", int'(oe_seen), 0);
    read_status(s);
    check("R9 busy with latch clear", int'(s), 8'h01);
    latch_on();
    read_status(s);
    check("R10 latch ignored while busy", int'(s), 8'h01);
    wait_idle();
    read_status(s);
    check("R10 latch still clear after busy", int'(s), 8'h00);
    for (int k = 0; k < 3; k++) exp_reg[40 + k] = data_of(9, k);
    check_region("R5 region programmed at offset");

    // one-time lock
    latch_on();
    read_status(s);
    check("R8 latch set before second attempt", int'(s), 8'h02);
    prog(3, 2, 0, 6'd0, 5);
    read_status(s);
    check("R8 second program aborts and clears latch", int'(s), 8'h00);
    wait_idle();
    check_region("R8 region unchanged after lock");
    read_buf(0, bv);
    check("R11 buffer overwritten by later command", int'(bv), int'(data_of(5, 0)));
    read_buf(40, bv);
    check("R11 buffer refilled with 0xFF", int'(bv), 8'hFF);

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule